// File: doc/BRIEF.md
# Per-Channel Averaging Result Bank

This block sits behind an analog-to-digital converter that cycles through many channels. Each conversion arrives as a 12-bit value with a channel number and a one-cycle valid strobe. The block keeps one result register per channel. A channel set to plain mode overwrites its register with every conversion it receives. A channel set to averaging mode adds each sample to a private accumulator and writes the mean only after a fixed number of samples. Channels in the two modes can share one conversion sequence, so their registers are refreshed at different rates.

The averaging depth is set by one 2-bit select that all ordinary channels share. The calibration channel is handled differently. It always averages over 16 samples, whatever the select. When its averaging is switched on, its first conversion is published at once, and each later result waits for 16 more samples. Software reads any result register combinationally by address. A one-hot strobe marks the cycle in which each register was written.

Top module: `avg_result_bank`

## Requirements
- R1: After reset every result register reads 0 and no update strobe is high.
- R2: A channel not in averaging mode writes the conversion data to its result register on every conversion of that channel. The new value and that channel's strobe appear one clock after the valid cycle.
- R3: A channel in averaging mode leaves its result register and strobe unchanged until its full sample count has been gathered.
- R4: For ordinary channels, select code 1 means 16 samples, code 2 means 64 and code 3 means 256.
- R5: Select code 0 turns averaging off for every ordinary channel, even when its enable bit is 1.
- R6: The calibration channel (channel 0) averages over exactly 16 samples whenever its enable bit is 1, for every select code including 0.
- R7: When calibration averaging is on, the first calibration conversion after it was enabled is written directly. Each later write happens after 16 more calibration conversions.
- R8: The averaged result is the sum of the samples shifted right by 4, 6 or 8 bits (the floor of the mean). This holds even when every sample is 4095. After each write the count starts again from zero.
- R9: A change of the select clears the partial sums of the ordinary channels. A change of one channel's enable bit clears that channel's partial sum, and for channel 0 it also re-arms the direct first write. Other channels keep their partial sums.
- R10: Each result write raises only that channel's bit of the update strobe, for exactly one cycle. No strobe is raised without a write.
- R11: The read port returns the result register selected by the read address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | CH_W (5) | Channel number of the result |
| res_data | input | DATA_W (12) | Conversion value |
| avg_en | input | NUM_CH (32) | Per-channel averaging enable |
| avg_sel | input | 2 | Averaging depth select |
| rd_addr | input | CH_W (5) | Result register read address |
| rd_data | output | DATA_W (12) | Selected result register |
| upd_strobe | output | NUM_CH (32) | One-cycle write strobe per channel |

## Verification
A wrong accumulator or counter in one lane does not show up at once. It shows as a written mean that differs from the floor of the true mean, or as a strobe that comes early or late. It becomes visible only at the end of that channel's window, up to 256 conversions of the channel later. For this reason the bench runs full windows at every depth, interleaves plain channels, and changes the configuration in the middle of a window. After every conversion it compares the whole strobe vector and the addressed register against an arithmetic model. A stuck calibration first-pass flag shows within one calibration conversion after that channel's enable is toggled.

// File: rtl/avg_pkg.sv
package avg_pkg;

   localparam int MAX_SHIFT = 8;
   localparam int CAL_SHIFT = 4;

   // Right shift that forms the mean for a given depth select; 0 = averaging off
   function automatic int sel_to_shift(input logic [1:0] sel);
      case (sel)
         2'd1:    return 4;
         2'd2:    return 6;
         2'd3:    return 8;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/avg_cfg_watch.sv
module avg_cfg_watch #(
   parameter int NUM_CH = 32,
   parameter int CAL_CH = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] avg_en,
   input  logic [1:0]        avg_sel,
   output logic [NUM_CH-1:0] clr_mask
);

   logic [NUM_CH-1:0] en_prev_q;
   logic [1:0]        sel_prev_q;
   logic              sel_chg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_prev_q  <= '0;
         sel_prev_q <= '0;
      end else begin
         en_prev_q  <= avg_en;
         sel_prev_q <= avg_sel;
      end
   end

   assign sel_chg = (avg_sel != sel_prev_q);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
      if (i == CAL_CH) begin : g_cal
         // calibration depth is fixed, so only its own enable matters
         assign clr_mask[i] = avg_en[i] ^ en_prev_q[i];
      end else begin : g_std
         assign clr_mask[i] = (avg_en[i] ^ en_prev_q[i]) | sel_chg;
      end
   end

   AST_SEL_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_sel != $past(avg_sel)) |-> ($countones(clr_mask) >= NUM_CH - 1)); // R9

endmodule

// File: rtl/avg_lane.sv
module avg_lane #(
   parameter int DATA_W = 12,
   parameter int ACC_W  = 20,
   parameter int CNT_W  = 8,
   parameter bit IS_CAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] din,
   input  logic              avg_on,
   input  logic [3:0]        shift,
   input  logic [CNT_W-1:0]  limit_m1,
   input  logic              clr,
   output logic [DATA_W-1:0] result,
   output logic              upd
);

   logic [ACC_W-1:0]  acc_q, acc_base, acc_sum;
   logic [CNT_W-1:0]  cnt_q, cnt_base;
   logic              first_pass;

   always_comb begin
      acc_base = clr ? '0 : acc_q;
      cnt_base = clr ? '0 : cnt_q;
      acc_sum  = acc_base + ACC_W'(din);
   end

   if (IS_CAL) begin : g_cal
      logic primed_q;
      assign first_pass = avg_on & (clr | ~primed_q);
      always_ff @(posedge clk) begin
         if (!rst_n)                   primed_q <= 1'b0;
         else if (hit && first_pass)   primed_q <= 1'b1;
         else if (clr)                 primed_q <= 1'b0;
      end

      AST_CAL_FIRST_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && first_pass) |=> (upd && result == $past(din))); // R7
   end else begin : g_std
      assign first_pass = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         result <= '0;
         upd    <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (hit) begin
            if (!avg_on || first_pass) begin
               result <= din;
               upd    <= 1'b1;
               acc_q  <= '0;
               cnt_q  <= '0;
            end else if (cnt_base == limit_m1) begin
               result <= DATA_W'(acc_sum >> shift);
               upd    <= 1'b1;
               acc_q  <= '0;
               cnt_q  <= '0;
            end else begin
               acc_q <= acc_sum;
               cnt_q <= cnt_base + 1'b1;
            end
         end else if (clr) begin
            acc_q <= '0;
            cnt_q <= '0;
         end
      end
   end

   AST_PLAIN_EVERY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !avg_on) |=> (upd && result == $past(din))); // R2

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q <= limit_m1)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(acc_q) <= 32'(cnt_q) * ((32'd1 << DATA_W) - 32'd1))); // R8

   AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> $past(hit)); // R10

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> (cnt_q == '0 && acc_q == '0)); // R9

endmodule

// File: rtl/avg_result_bank.sv
module avg_result_bank #(
   parameter int NUM_CH = 32,
   parameter int DATA_W = 12,
   parameter int CAL_CH = 0,
   parameter int ACC_W  = 20,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_chan,
   input  logic [DATA_W-1:0] res_data,
   input  logic [NUM_CH-1:0] avg_en,
   input  logic [1:0]        avg_sel,
   input  logic [CH_W-1:0]   rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] upd_strobe
);
   import avg_pkg::*;

   localparam int CNT_W = MAX_SHIFT;

   initial begin
      if (ACC_W < DATA_W + MAX_SHIFT)
         $error("ACC_W too small for the deepest average");
      if (CAL_CH >= NUM_CH)
         $error("CAL_CH outside channel range");
      if (NUM_CH < 1)
         $error("NUM_CH must be positive");
   end

   logic [NUM_CH-1:0] clr_mask;
   logic [DATA_W-1:0] res_arr [NUM_CH];
   logic [3:0]        std_shift;
   logic [CNT_W-1:0]  std_limit_m1;
   logic              std_avg_any;

   assign std_shift    = 4'(sel_to_shift(avg_sel));
   assign std_limit_m1 = CNT_W'((32'd1 << std_shift) - 32'd1);
   assign std_avg_any  = (avg_sel != 2'd0);

   avg_cfg_watch #(
      .NUM_CH (NUM_CH),
      .CAL_CH (CAL_CH)
   ) i_cfg_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .avg_en   (avg_en),
      .avg_sel  (avg_sel),
      .clr_mask (clr_mask)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      localparam bit LANE_CAL = (i == CAL_CH);
      logic             lane_hit;
      logic             lane_avg_on;
      logic [3:0]       lane_shift;
      logic [CNT_W-1:0] lane_limit_m1;

      assign lane_hit = res_valid && (res_chan == CH_W'(i));

      if (LANE_CAL) begin : g_cfg_cal
         assign lane_avg_on   = avg_en[i];
         assign lane_shift    = 4'(CAL_SHIFT);
         assign lane_limit_m1 = CNT_W'((1 << CAL_SHIFT) - 1);
      end else begin : g_cfg_std
         assign lane_avg_on   = avg_en[i] & std_avg_any;
         assign lane_shift    = std_shift;
         assign lane_limit_m1 = std_limit_m1;
      end

      avg_lane #(
         .DATA_W (DATA_W),
         .ACC_W  (ACC_W),
         .CNT_W  (CNT_W),
         .IS_CAL (LANE_CAL)
      ) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (lane_hit),
         .din      (res_data),
         .avg_on   (lane_avg_on),
         .shift    (lane_shift),
         .limit_m1 (lane_limit_m1),
         .clr      (clr_mask[i]),
         .result   (res_arr[i]),
         .upd      (upd_strobe[i])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CH; k++)
         if (rd_addr == CH_W'(k)) rd_data = res_arr[k];
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_strobe)); // R10

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_strobe != '0 && !res_valid) |=> (upd_strobe == '0)); // R10

endmodule

// File: tb/test_avg_result_bank.sv
module test_avg_result_bank;

   localparam int NCH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [4:0]  res_chan = '0;
   logic [11:0] res_data = '0;
   logic [31:0] avg_en = '0;
   logic [1:0]  avg_sel = '0;
   logic [4:0]  rd_addr = '0;
   logic [11:0] rd_data;
   logic [31:0] upd_strobe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int macc [NCH];
   int mcnt [NCH];
   int mres [NCH];
   bit mprim;

   always #10 clk = ~clk;

   avg_result_bank i_avg_result_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .res_valid  (res_valid),
      .res_chan   (res_chan),
      .res_data   (res_data),
      .avg_en     (avg_en),
      .avg_sel    (avg_sel),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .upd_strobe (upd_strobe)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [31:0] nen, input logic [1:0] nsel);
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
         if ((nen[i] != avg_en[i]) || (i != 0 && nsel != avg_sel)) begin
            macc[i] = 0;
            mcnt[i] = 0;
         end
      end
      if (nen[0] != avg_en[0]) mprim = 1'b0;
      avg_en  = nen;
      avg_sel = nsel;
   endtask

   task automatic conv(input int ch, input int d, input string tag);
      bit   avg;
      bit   wr;
      int   n;
      logic [31:0] exp_s;
      @(negedge clk);
      res_valid = 1'b1;
      res_chan  = 5'(ch);
      res_data  = 12'(d);
      rd_addr   = 5'(ch);
      avg = (ch == 0) ? avg_en[0] : (avg_en[ch] && avg_sel != 2'd0);
      n   = (ch == 0) ? 16 : (16 << (2 * (int'(avg_sel) - 1)));
      wr  = 1'b0;
      if (!avg) begin
         mres[ch] = d; wr = 1'b1;
      end else if (ch == 0 && !mprim) begin
         mres[ch] = d; mprim = 1'b1; macc[ch] = 0; mcnt[ch] = 0; wr = 1'b1;
      end else begin
         macc[ch] += d;
         mcnt[ch]++;
         if (mcnt[ch] == n) begin
            mres[ch] = macc[ch] / n; macc[ch] = 0; mcnt[ch] = 0; wr = 1'b1;
         end
      end
      exp_s = wr ? (32'd1 << ch) : 32'd0;
      @(negedge clk);
      res_valid = 1'b0;
      check(tag, "strobe", upd_strobe, exp_s);
      check(tag, "result", 32'(rd_data), 32'(mres[ch]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin macc[i] = 0; mcnt[i] = 0; mres[i] = 0; end
      mprim = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 and R11: reset contents readable at every address
      for (int a = 0; a < NCH; a++) begin
         @(negedge clk);
         rd_addr = 5'(a);
         #1 check("R1", "reset result", 32'(rd_data), 32'd0);
      end
      check("R1", "reset strobe", upd_strobe, 32'd0);

      // R5 and R2: select 0 with all enables set -> plain writes (channel 0 kept off)
      set_cfg(32'hFFFF_FFFE, 2'd0);
      for (int c = 1; c < NCH; c++) conv(c, (c * 131 + 7) & 12'hFFF, "R5");
      for (int c = 1; c < NCH; c += 3) conv(c, (c * 59 + 300) & 12'hFFF, "R2");

      // R11: every register read back by address after the writes
      for (int a = 0; a < NCH; a++) begin
         @(negedge clk);
         rd_addr = 5'(a);
         #1 check("R11", "readback", 32'(rd_data), 32'(mres[a]));
      end

      // R3 R4 R6 R7 R8: depth 16, ch5 averaged, ch1 plain, cal channel on
      set_cfg(32'h0000_0021, 2'd1);
      for (int k = 0; k < 40; k++) begin
         conv(5, (k * 97 + 13) & 12'hFFF, "R3");
         conv(1, (k * 211) & 12'hFFF, "R2");
         conv(0, (k * 73 + 5) & 12'hFFF, "R7");
      end

      // R4 R6: depth 64, cal stays at 16
      set_cfg(32'h0000_0021, 2'd2);
      for (int k = 0; k < 130; k++) begin
         conv(5, (k * 113 + 1) & 12'hFFF, "R4");
         if (k % 2 == 0) conv(0, (k * 29 + 900) & 12'hFFF, "R6");
      end

      // R8: depth 256 with full-scale samples and non-multiple sums
      set_cfg(32'h0000_0020, 2'd3);
      for (int k = 0; k < 256; k++) conv(5, 4095, "R8");
      for (int k = 0; k < 256; k++) conv(5, (k * 7 + 3) & 12'hFFF, "R8");

      // R6: cal averages 16 even with select 0
      set_cfg(32'h0000_0001, 2'd0);
      for (int k = 0; k < 34; k++) conv(0, (k * 41 + 17) & 12'hFFF, "R6");
      conv(5, 1234, "R5");

      // R9: mid-window changes
      set_cfg(32'h0000_00A1, 2'd2);
      for (int k = 0; k < 10; k++) conv(5, 100 + k, "R9");
      for (int k = 0; k < 5; k++) conv(7, 2000 + k, "R9");
      set_cfg(32'h0000_0021, 2'd2);          // ch7 enable dropped, ch5 keeps sum
      conv(7, 555, "R9");
      for (int k = 0; k < 60; k++) conv(5, 3000 - k, "R9");
      for (int k = 0; k < 20; k++) conv(5, 50 + k, "R9");
      set_cfg(32'h0000_0021, 2'd1);          // select change clears ch5
      for (int k = 0; k < 20; k++) conv(5, 4000 - k * 3, "R9");
      for (int k = 0; k < 7; k++) conv(0, 10 * k, "R9");
      set_cfg(32'h0000_0020, 2'd1);          // cal enable off
      conv(0, 77, "R9");
      set_cfg(32'h0000_0021, 2'd1);          // cal re-armed: direct first write
      for (int k = 0; k < 18; k++) conv(0, 600 + k * 11, "R7");

      // R10: idle cycle has no strobe
      @(negedge clk);
      check("R10", "idle strobe", upd_strobe, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule